// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Engine

This block is the memory side of a three-wire serial EEPROM link. A host raises chip select, toggles the serial clock and presents data bits on a single input line. The engine takes in a start bit, a two-bit opcode and an address, and then runs one of seven commands against a 1 Kbit internal array. A strap input sets the word format: 64 words of 16 bits, or 128 words of 8 bits. Read data leaves on a single output line that has its own output enable.

Programming commands are refused until the host unlocks them, and they are refused again after a lock command or a reset. Every programming command starts a self-timed program cycle whose length is a parameter in system clock cycles. A host that drops chip select and raises it again during that cycle sees the busy or ready state on the output line.

The serial clock, chip select and data input are sampled in the system clock domain. The serial clock is edge-detected there, so the serial clock must run several times slower than the system clock.

Top module: `serial_eeprom_slave`

## Requirements
- R1: While chip select is high and no command is in progress, the engine ignores zeros sampled on serial clock rising edges. The first 1 is the start bit. The 2-bit opcode follows it MSB first, then the address MSB first.
- R2: With `orgIn` high the array is 64 words of 16 bits with a 6-bit address. With `orgIn` low it is 128 words of 8 bits with a 7-bit address. Every address reaches its own word.
- R3: Opcode 10 reads. After the last address bit, `doOe` is high and `doOut` shows a 0 dummy bit. Each later serial clock rising edge moves `doOut` to the next data bit, MSB first. Reads work whether programming is locked or unlocked.
- R4: After reset, programming is locked. Opcode 01 (write), opcode 11 (erase), erase-all and write-all then leave the array unchanged. Opcode 00 with the two top address bits 11 unlocks programming, and 00 with 00 locks it again. The remaining address bits are don't-care.
- R5: Opcode 01 stores the data word that follows the address, MSB first, with no erase needed first. Opcode 11 sets every bit of the addressed word to 1.
- R6: Opcode 00 with top address bits 10 sets every word to all ones. Opcode 00 with top address bits 01 writes the data word that follows to every word.
- R7: A programming command starts a program cycle of `BUSY_CYCLES` clocks. Write and write-all start it at the last data bit; erase and erase-all start it at the last address bit. If chip select is dropped and raised again during the cycle, `doOe` goes high and `doOut` reads 0 while the cycle runs and 1 once it has finished.
- R8: If chip select is raised only after the program cycle has ended, no status is shown and `doOe` stays low.
- R9: `doOe` is low whenever chip select is low.
- R10: A command clocked in while a program cycle is running is ignored.
- R11: If chip select drops before a command is complete, the command is abandoned and the array is unchanged.
- R12: After reset, `doOe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csIn | input | 1 | Chip select, active high |
| skIn | input | 1 | Serial clock from the host |
| diIn | input | 1 | Serial data from the host |
| orgIn | input | 1 | Word format: 1 selects 16-bit words, 0 selects 8-bit words |
| doOut | output | 1 | Serial read data or ready/busy status |
| doOe | output | 1 | Output enable for doOut |

## Verification
The bench sets `BUSY_CYCLES` to 64. That keeps a whole program cycle short enough for the bench to observe the busy phase, the ready phase and the late-select case within a few hundred clocks. The default stays sized for a 10 ms cycle at 50 MHz. The bench switches `orgIn` at run time, so both word formats are exercised, including the highest 7-bit address and write-all in both widths.

// File: rtl/sereep_pkg.sv
package sereep_pkg;
  parameter int MEM_BITS  = 1024;
  parameter int WIDE_W    = 16;
  parameter int NARROW_W  = 8;
  localparam int BYTES     = MEM_BITS / NARROW_W;
  localparam int NARROW_AW = $clog2(BYTES);
  localparam int WIDE_AW   = NARROW_AW - 1;
  localparam int HDR_W     = NARROW_AW + 2;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_READ, S_HOLD} ctlState_e;
  typedef enum logic [1:0] {OP_EXT = 2'b00, OP_WRITE = 2'b01,
                            OP_READ = 2'b10, OP_ERASE = 2'b11} opcode_e;

  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_FILL   = 2'b01;
  localparam logic [1:0] EXT_CLEAR  = 2'b10;
  localparam logic [1:0] EXT_UNLOCK = 2'b11;

  typedef struct packed {
    logic                 dataShift;
    logic                 readLoad;
    logic                 readShift;
    logic                 memWr;
    logic                 memAll;
    logic                 memOnes;
    logic [NARROW_AW-1:0] addr;
  } dpStrobe_t;
endpackage

// File: rtl/sereep_dpath.sv
module sereep_dpath
  import sereep_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wide,
  input  logic      diS,
  input  dpStrobe_t stb,
  output logic      doBit
);
  logic [NARROW_W-1:0] mem [BYTES];
  logic [WIDE_W-2:0]   dataReg;
  logic [WIDE_W:0]     outReg;
  logic [WIDE_W-1:0]   wrWord;
  logic [WIDE_W-1:0]   rdWord;

  // incoming word includes the bit arriving on this edge
  always_comb begin
    if (stb.memOnes)   wrWord = '1;
    else if (wide)     wrWord = {dataReg, diS};
    else               wrWord = {{NARROW_W{1'b0}}, dataReg[NARROW_W-2:0], diS};
  end

  // 16-bit word n lives in bytes 2n (upper half) and 2n+1 (lower half)
  always_comb begin
    if (wide) rdWord = {mem[{stb.addr[WIDE_AW-1:0], 1'b0}], mem[{stb.addr[WIDE_AW-1:0], 1'b1}]};
    else      rdWord = {mem[stb.addr], {NARROW_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (stb.memWr) begin
      for (int i = 0; i < BYTES; i++) begin
        if (stb.memAll || (wide ? (stb.addr[WIDE_AW-1:0] == WIDE_AW'(i / 2))
                                : (stb.addr == NARROW_AW'(i))))
          mem[i] <= (wide && (i % 2 == 0)) ? wrWord[WIDE_W-1:NARROW_W] : wrWord[NARROW_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      outReg  <= '0;
    end else begin
      if (stb.dataShift) dataReg <= {dataReg[WIDE_W-3:0], diS};
      if (stb.readLoad)       outReg <= {1'b0, rdWord};
      else if (stb.readShift) outReg <= {outReg[WIDE_W-1:0], 1'b0};
    end
  end

  assign doBit = outReg[WIDE_W];

  // R3: the first bit presented after the address is the dummy zero
  p_dummy_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.readLoad |=> !doBit);
endmodule

// File: rtl/sereep_ctrl.sv
module sereep_ctrl
  import sereep_pkg::*;
#(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csIn,
  input  logic      skIn,
  input  logic      diIn,
  input  logic      wide,
  input  logic      doBit,
  output logic      diS,
  output dpStrobe_t stb,
  output logic      doOut,
  output logic      doOe
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic csM, csS, csP, skM, skS, skP, diM;
  logic skRise, csRise, step, busy, hdrDone, dataDone;
  ctlState_e state;
  logic [HDR_W-2:0] hdr;
  logic [HDR_W-1:0] nextHdr;
  logic [4:0] bitCnt, hdrLast, dataLast;
  opcode_e decOp;
  logic [1:0] decExt;
  logic [NARROW_AW-1:0] decAddr, addrQ;
  logic wenQ, allQ, statusQ;
  logic [BUSY_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) {csM, csS, csP, skM, skS, skP, diM, diS} <= '0;
    else begin
      csM <= csIn; csS <= csM; csP <= csS;
      skM <= skIn; skS <= skM; skP <= skS;
      diM <= diIn; diS <= diM;
    end
  end

  assign skRise   = skS & ~skP;
  assign csRise   = csS & ~csP;
  assign step     = csS & skRise;
  assign busy     = (busyCnt != '0);
  assign nextHdr  = {hdr, diS};
  assign hdrLast  = wide ? 5'(WIDE_AW + 1) : 5'(NARROW_AW + 1);
  assign dataLast = wide ? 5'(WIDE_W - 1) : 5'(NARROW_W - 1);
  assign decOp    = opcode_e'(wide ? nextHdr[WIDE_AW+1:WIDE_AW] : nextHdr[NARROW_AW+1:NARROW_AW]);
  assign decExt   = wide ? nextHdr[WIDE_AW-1:WIDE_AW-2] : nextHdr[NARROW_AW-1:NARROW_AW-2];
  assign decAddr  = wide ? NARROW_AW'(nextHdr[WIDE_AW-1:0]) : nextHdr[NARROW_AW-1:0];
  assign hdrDone  = (state == S_HDR) && step && (bitCnt == hdrLast);
  assign dataDone = (state == S_DATA) && step && (bitCnt == dataLast);

  always_comb begin
    stb = '0;
    stb.addr = (state == S_HDR) ? decAddr : addrQ;
    if (hdrDone) begin
      if (decOp == OP_READ) stb.readLoad = 1'b1;
      if (wenQ && decOp == OP_ERASE) begin
        stb.memWr = 1'b1; stb.memOnes = 1'b1;
      end
      if (wenQ && decOp == OP_EXT && decExt == EXT_CLEAR) begin
        stb.memWr = 1'b1; stb.memOnes = 1'b1; stb.memAll = 1'b1;
      end
    end
    if (state == S_DATA && step) begin
      stb.dataShift = 1'b1;
      if (dataDone && wenQ) begin
        stb.memWr = 1'b1; stb.memAll = allQ;
      end
    end
    if (state == S_READ && step) stb.readShift = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; hdr <= '0; bitCnt <= '0; addrQ <= '0;
      wenQ <= 1'b0; allQ <= 1'b0; statusQ <= 1'b0; busyCnt <= '0;
    end else begin
      if (stb.memWr) busyCnt <= BUSY_W'(BUSY_CYCLES);
      else if (busy) busyCnt <= busyCnt - BUSY_W'(1);
      if (!csS) begin
        state <= S_IDLE; statusQ <= 1'b0;
      end else begin
        case (state)
          S_IDLE: begin
            if (csRise && busy) begin
              state <= S_HOLD; statusQ <= 1'b1;
            end else if (step && diS && !busy) begin
              state <= S_HDR; bitCnt <= '0; hdr <= '0;
            end
          end
          S_HDR: if (step) begin
            hdr <= nextHdr[HDR_W-2:0];
            bitCnt <= bitCnt + 5'd1;
            if (hdrDone) begin
              addrQ <= decAddr; bitCnt <= '0;
              case (decOp)
                OP_READ:  state <= S_READ;
                OP_WRITE: begin state <= S_DATA; allQ <= 1'b0; end
                OP_ERASE: state <= S_HOLD;
                default: begin
                  state <= S_HOLD;
                  if (decExt == EXT_UNLOCK) wenQ <= 1'b1;
                  if (decExt == EXT_LOCK)   wenQ <= 1'b0;
                  if (decExt == EXT_FILL) begin state <= S_DATA; allQ <= 1'b1; end
                end
              endcase
            end
          end
          S_DATA: if (step) begin
            bitCnt <= bitCnt + 5'd1;
            if (dataDone) state <= S_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  assign doOe  = csS && ((state == S_READ) || statusQ);
  assign doOut = statusQ ? ~busy : doBit;

  // R10: no programming strobe can land while a cycle is still running
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.memWr);
  // R7: a started cycle loads the full length and then counts down by one
  p_cycle_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWr |=> (busyCnt == BUSY_W'(BUSY_CYCLES)));
  p_cycle_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busyCnt == $past(busyCnt) - BUSY_W'(1)));
  // R8: status mode is entered only during a running cycle
  p_status_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ) |-> $past(busy));
  // R11: a dropped select returns the sequencer to idle
  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !csS |=> (state == S_IDLE));
  // R4: programming strobes only while unlocked
  p_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWr |-> wenQ);
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import sereep_pkg::*;
#(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  input  logic orgIn,
  output logic doOut,
  output logic doOe
);
  dpStrobe_t stb;
  logic diS, doBit;

  sereep_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .wide(orgIn), .doBit(doBit), .diS(diS), .stb(stb),
    .doOut(doOut), .doOe(doOe)
  );

  sereep_dpath uDpath (
    .clk(clk), .rstN(rstN), .wide(orgIn), .diS(diS), .stb(stb), .doBit(doBit)
  );
endmodule

// File: tb/tb_serial_eeprom_slave.sv
`timescale 1ns/1ps
module tb_serial_eeprom_slave;
  localparam int BUSY = 64;
  // {wide, addr[6:0], data[15:0]}; addresses chosen so no two entries share a byte
  localparam logic [23:0] VEC [8] = '{
    {1'b1, 7'd0,   16'hA5C3}, {1'b0, 7'd2,   16'h0081},
    {1'b1, 7'd5,   16'h8001}, {1'b0, 7'd64,  16'h00FE},
    {1'b1, 7'd40,  16'h5A0F}, {1'b0, 7'd100, 16'h0033},
    {1'b0, 7'd125, 16'h00C4}, {1'b1, 7'd63,  16'hFFFE}};

  logic clk = 0, rstN = 0, cs = 0, sk = 0, di = 0, org = 1;
  logic doOut, doOe;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  serial_eeprom_slave #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rstN(rstN), .csIn(cs), .skIn(sk), .diIn(di), .orgIn(org),
    .doOut(doOut), .doOe(doOe));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n); repeat (n) @(negedge clk); endtask
  function automatic int aw(); return org ? 6 : 7; endfunction
  function automatic int ww(); return org ? 16 : 8; endfunction

  task automatic clockBit(input logic b, output logic s);
    di = b; waitClk(8); s = doOut; sk = 1; waitClk(8); sk = 0;
  endtask
  task automatic sendBits(input logic [31:0] v, input int n);
    logic s;
    for (int i = n - 1; i >= 0; i--) clockBit(v[i], s);
  endtask
  task automatic beginCmd(); cs = 1; waitClk(4); endtask
  task automatic endCmd(); waitClk(4); cs = 0; waitClk(6); endtask
  task automatic header(input logic [1:0] op, input logic [6:0] a);
    sendBits({29'd0, 1'b1, op}, 3); sendBits({25'd0, a}, aw());
  endtask
  task automatic extCmd(input logic [1:0] code);
    beginCmd(); sendBits({27'd0, 3'b100, code}, 5); sendBits(0, aw() - 2); endCmd();
  endtask
  task automatic writeWord(input logic [6:0] a, input logic [15:0] d);
    beginCmd(); header(2'b01, a); sendBits({16'd0, d}, ww()); endCmd(); waitClk(BUSY + 20);
  endtask
  task automatic eraseWord(input logic [6:0] a);
    beginCmd(); header(2'b11, a); endCmd(); waitClk(BUSY + 20);
  endtask
  task automatic readWord(input int zeros, input logic [6:0] a,
                          output logic [15:0] v, output logic dummy);
    logic s;
    beginCmd();
    for (int i = 0; i < zeros; i++) clockBit(1'b0, s);
    header(2'b10, a);
    v = '0;
    clockBit(1'b0, dummy);
    for (int i = 0; i < ww(); i++) begin clockBit(1'b0, s); v = {v[14:0], s}; end
    endCmd();
  endtask

  initial begin
    waitClk(150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v; logic d;
    waitClk(5); rstN = 1; waitClk(3);
    check("R12 reset oe", doOe, 0);
    extCmd(2'b11);

    // table: write then read back each entry (R5, R3, R2)
    foreach (VEC[i]) begin
      org = VEC[i][23];
      writeWord(VEC[i][22:16], VEC[i][15:0]);
      readWord(0, VEC[i][22:16], v, d);
      check("R5 write/read", v, org ? VEC[i][15:0] : {8'h00, VEC[i][7:0]});
      check("R3 dummy bit", d, 0);
    end
    // R2: entries kept apart in both formats
    foreach (VEC[i]) begin
      org = VEC[i][23];
      readWord(0, VEC[i][22:16], v, d);
      check("R2 distinct words", v, org ? VEC[i][15:0] : {8'h00, VEC[i][7:0]});
    end

    org = 1;
    writeWord(7'd3, 16'h1234);
    readWord(3, 7'd3, v, d);
    check("R1 leading zeros", v, 16'h1234);
    eraseWord(7'd2);
    readWord(0, 7'd2, v, d);
    check("R5 erase", v, 16'hFFFF);

    // R7 status while busy, R10 command during cycle ignored
    beginCmd(); header(2'b01, 7'd20); sendBits(32'h3C3C, 16);
    waitClk(2); cs = 0; waitClk(4); cs = 1; waitClk(6);
    check("R7 status oe", doOe, 1);
    check("R7 busy reads 0", doOut, 0);
    header(2'b01, 7'd20); sendBits(32'hC3C3, 16);
    check("R7 ready reads 1", doOut, 1);
    cs = 0; waitClk(6);
    check("R9 oe low with cs low", doOe, 0);
    waitClk(BUSY + 20);
    readWord(0, 7'd20, v, d);
    check("R10 ignored during cycle", v, 16'h3C3C);

    // R8 late select shows no status
    writeWord(7'd21, 16'h0101);
    cs = 1; waitClk(8);
    check("R8 no late status", doOe, 0);
    cs = 0; waitClk(6);

    // R11 abort mid-data
    writeWord(7'd12, 16'h0F0F);
    beginCmd(); header(2'b01, 7'd12); sendBits(32'hFF, 8);
    waitClk(2); cs = 0; waitClk(BUSY + 20);
    readWord(0, 7'd12, v, d);
    check("R11 abort keeps word", v, 16'h0F0F);

    // R6 fill all and clear all
    org = 0;
    beginCmd(); sendBits(32'h11, 5); sendBits(0, aw() - 2); sendBits(32'h5A, 8); endCmd();
    waitClk(BUSY + 20);
    readWord(0, 7'd0, v, d);   check("R6 fill byte 0", v, 16'h005A);
    readWord(0, 7'd127, v, d); check("R6 fill byte 127", v, 16'h005A);
    org = 1;
    readWord(0, 7'd33, v, d);  check("R6 fill wide", v, 16'h5A5A);
    extCmd(2'b10); waitClk(BUSY + 20);
    readWord(0, 7'd63, v, d);  check("R6 clear wide", v, 16'hFFFF);
    org = 0;
    readWord(0, 7'd77, v, d);  check("R6 clear narrow", v, 16'h00FF);

    // R4 locked programming
    org = 1;
    writeWord(7'd3, 16'h1234);
    extCmd(2'b00);
    writeWord(7'd3, 16'hBEEF);
    readWord(0, 7'd3, v, d);   check("R4 write locked", v, 16'h1234);
    eraseWord(7'd3);
    extCmd(2'b10); waitClk(BUSY + 20);
    readWord(0, 7'd3, v, d);   check("R4 erase locked", v, 16'h1234);

    // R12/R4 reset returns to locked
    extCmd(2'b11);
    rstN = 0; waitClk(3); rstN = 1; waitClk(3);
    check("R12 oe after reset", doOe, 0);
    writeWord(7'd3, 16'h7777);
    readWord(0, 7'd3, v, d);   check("R4 locked after reset", v, 16'h1234);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule